// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block sequences the clock source and the low-power states of a small controller core. The system clock comes from one of three sources: a fast oscillator, a slow oscillator, or a 4x multiplier fed from the fast oscillator. The block also tracks five operating modes: NORMAL, SLOW, IDLE2, IDLE1 and STOP. It does not produce a derived clock. It produces `sys_ce`, a one-cycle enable in the reference clock domain. The reference clock runs at the multiplier's output rate, so the fast oscillator is a quarter of it, and the slow oscillator is `LOSC_DIV` times slower than the reference.

Software drives the block through single-cycle write strobes: source select, gear, multiplier start or stop, fast oscillator on or off, and standby-mode select. A separate strobe models the sleep instruction. When a request would break an ordering rule, the block refuses it, leaves its state unchanged and raises `req_err` for one cycle. The ordering rules are: the multiplier is stopped before the fast oscillator is turned off; the multiplier is deselected before it is stopped; no STOP entry while the multiplier is on; no multiplier control in SLOW.

A build parameter selects the clock configuration: single (fast oscillator only), dual (adds the slow oscillator) or triple (adds the multiplier). A configuration without the slow oscillator refuses every SLOW request. A configuration without the multiplier refuses every multiplier request. The requirements below use the triple configuration. Mode codes on `mode` are: NORMAL=0, SLOW=1, IDLE2=2, IDLE1=3, STOP=4.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset, the block is in the following state.
  - `mode` is 0 (NORMAL) and the fast oscillator is the source.
  - The gear is divide-by-16, so `sys_ce` pulses every 128 reference cycles.
  - `cpu_run`, `io_run`, `hosc_run` and `losc_run` are 1; `mul_run` and `req_err` are 0.
- R2: With the fast oscillator as source, the `sys_ce` period is 8 × gear divisor. Gear codes 0, 1, 2, 3 and 4 give divisors 1, 2, 4, 8 and 16. Codes 5, 6 and 7 give 16.
- R3: Multiplier start (`mul_wr` with `mul_start`=1) is accepted while the fast oscillator is on, and sets `mul_run`. Source code 2 (multiplier) is accepted only after `mul_lock` has been high for `LOCK_CYCLES` consecutive cycles; before that it is refused. Once selected, the period is 2 × gear divisor.
- R4: Source code 1 selects the slow oscillator. `mode` becomes 1 (SLOW) and the period is 2 × `LOSC_DIV`. Source code 0 returns to NORMAL on the fast oscillator.
- R5: Any multiplier write in SLOW is refused: `req_err` pulses and `mul_run` is unchanged.
- R6: Stopping the multiplier while it is the source is refused. A sleep with standby code 2 (STOP) while the multiplier is on is refused and `mode` stays the same. After source code 0 is selected, the stop is accepted.
- R7: Turning the fast oscillator off (`hosc_wr` with `hosc_on_req`=0) is refused while the multiplier is on, or while the source is not the slow oscillator. `hosc_run` stays 1 in both cases.
- R8: A source or gear change never cuts a period short. The period in progress completes at its old length, and the new length applies from the next pulse.
- R9: Sleep with standby code 0 enters IDLE2: `cpu_run`=0 and `io_run`=1, and `sys_ce` keeps pulsing. Sleep with standby code 1 enters IDLE1: `io_run`=0, `sys_ce` stops, and both oscillators keep running. `wake_irq` returns to the mode held before sleep.
- R10: Sleep with standby code 2 enters STOP, and every run output is 0. On `wake_irq`, `hosc_run` rises at once while `cpu_run` stays 0 for `WARM_CYCLES` cycles. The block then resumes the mode and source held before STOP.
- R11: Standby code 3 and source code 3 are refused. Any write or sleep while the CPU is halted (IDLE2, IDLE1, STOP) is refused. Each refusal gives a `req_err` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (multiplier output rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_wr | input | 1 | Source select write strobe |
| src_sel | input | 2 | 0 fast osc, 1 slow osc, 2 multiplier, 3 reserved |
| gear_wr | input | 1 | Gear write strobe |
| gear_sel | input | 3 | Gear code |
| mul_wr | input | 1 | Multiplier control write strobe |
| mul_start | input | 1 | 1 start, 0 stop |
| hosc_wr | input | 1 | Fast oscillator control write strobe |
| hosc_on_req | input | 1 | 1 on, 0 off |
| stby_wr | input | 1 | Standby mode write strobe |
| stby_sel | input | 2 | 0 IDLE2, 1 IDLE1, 2 STOP, 3 reserved |
| sleep_req | input | 1 | Sleep instruction strobe |
| wake_irq | input | 1 | Interrupt wake |
| mul_lock | input | 1 | Multiplier lock ready |
| mode | output | 3 | Current operating mode |
| sys_ce | output | 1 | System clock enable pulse |
| cpu_run | output | 1 | CPU domain enable |
| io_run | output | 1 | I/O domain enable |
| hosc_run | output | 1 | Fast oscillator enable |
| losc_run | output | 1 | Slow oscillator enable |
| mul_run | output | 1 | Multiplier enable |
| req_err | output | 1 | One-cycle pulse on a refused request |

## Verification
The assertions rely on three assumptions about the inputs:
- Software raises at most one of the write and sleep strobes in a cycle. This block has no valid/ready stream; every pin is a plain control pin.
- `mul_lock` is only meaningful while the multiplier runs.
- `wake_irq` arrives only after the sleep that it ends.

The stimulus meets all three. Every task pulses a single strobe for one cycle between falling edges. `mul_lock` is raised after the multiplier start and dropped after it stops. Wakes are issued only once the idle or stop mode has been observed on `mode`.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [2:0] {
    M_NORMAL = 3'd0, M_SLOW = 3'd1, M_IDLE2 = 3'd2, M_IDLE1 = 3'd3, M_STOP = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    S_HOSC = 2'd0, S_LOSC = 2'd1, S_MUL = 2'd2, S_RSVD = 2'd3
  } src_e;

  localparam int unsigned CFG_SINGLE = 0;
  localparam int unsigned CFG_DUAL   = 1;
  localparam int unsigned CFG_TRIPLE = 2;
  localparam int unsigned MUL_FACTOR = 4;
  localparam int unsigned GEAR_MAX   = 16;

  function automatic int unsigned gear_div(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      default: return GEAR_MAX;
    endcase
  endfunction
endpackage

// File: rtl/cpm_qual_cnt.sv
module cpm_qual_cnt #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  assign done = (cnt_q == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cpm_ce_div.sv
module cpm_ce_div
  import cpm_pkg::*;
#(
  parameter int unsigned LOSC_DIV = 100,
  parameter int unsigned PER_W    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  src_e       src,
  input  logic [2:0] gear,
  output logic       tick
);
  localparam int unsigned RST_PER = 2 * MUL_FACTOR * GEAR_MAX;

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] reload;
  int unsigned      per_i;

  always_comb begin
    case (src)
      S_MUL:   per_i = 2 * gear_div(gear);
      S_LOSC:  per_i = 2 * LOSC_DIV;
      default: per_i = 2 * MUL_FACTOR * gear_div(gear);
    endcase
    reload = PER_W'(per_i - 1);
  end

  assign tick = (cnt_q == '0);

  // reload only at the end of a period, so changes land on a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= PER_W'(RST_PER - 1);
    else if (tick) cnt_q <= reload;
    else           cnt_q <= cnt_q - 1'b1;
  end

  AST_CE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R8
endmodule

// File: rtl/cpm_fsm.sv
module cpm_fsm
  import cpm_pkg::*;
#(
  parameter bit HAS_LOSC = 1'b1,
  parameter bit HAS_MUL  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_wr,
  input  logic [1:0] src_sel,
  input  logic       gear_wr,
  input  logic [2:0] gear_sel,
  input  logic       mul_wr,
  input  logic       mul_start,
  input  logic       hosc_wr,
  input  logic       hosc_on_req,
  input  logic       stby_wr,
  input  logic [1:0] stby_sel,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       mul_locked,
  input  logic       warm_done,
  output mode_e      mode_q,
  output src_e       src_q,
  output logic [2:0] gear_q,
  output logic       mul_on_q,
  output logic       hosc_on_q,
  output logic       warming_q,
  output logic       err_q
);
  mode_e      mode_d;
  src_e       src_d;
  logic [2:0] gear_d;
  logic [1:0] stby_q, stby_d;
  logic       mul_d, hosc_d, warm_d, err_d;
  logic       cpu_active, any_req;
  mode_e      resume;

  assign cpu_active = (mode_q == M_NORMAL) || (mode_q == M_SLOW);
  assign any_req    = src_wr | gear_wr | mul_wr | hosc_wr | stby_wr | sleep_req;
  assign resume     = (src_q == S_LOSC) ? M_SLOW : M_NORMAL;

  always_comb begin
    mode_d = mode_q;  src_d = src_q;   gear_d = gear_q; stby_d = stby_q;
    mul_d  = mul_on_q; hosc_d = hosc_on_q; warm_d = warming_q; err_d = 1'b0;
    if (!cpu_active) begin
      err_d = any_req;
      if (mode_q == M_STOP) begin
        if (warming_q) begin
          if (warm_done) begin warm_d = 1'b0; mode_d = resume; end
        end else if (wake_irq) begin
          warm_d = 1'b1; hosc_d = 1'b1;
        end
      end else if (wake_irq) begin
        mode_d = resume;
      end
    end else if (sleep_req) begin
      case (stby_q)
        2'd0:    mode_d = M_IDLE2;
        2'd1:    mode_d = M_IDLE1;
        default: if (mul_on_q) err_d = 1'b1; else mode_d = M_STOP;
      endcase
    end else if (src_wr) begin
      case (src_sel)
        S_HOSC:  if (!hosc_on_q) err_d = 1'b1;
                 else begin src_d = S_HOSC; mode_d = M_NORMAL; end
        S_LOSC:  if (!HAS_LOSC) err_d = 1'b1;
                 else begin src_d = S_LOSC; mode_d = M_SLOW; end
        S_MUL:   if (!HAS_MUL || mode_q == M_SLOW || !mul_on_q || !mul_locked) err_d = 1'b1;
                 else begin src_d = S_MUL; mode_d = M_NORMAL; end
        default: err_d = 1'b1;
      endcase
    end else if (gear_wr) begin
      gear_d = gear_sel;
    end else if (mul_wr) begin
      if (!HAS_MUL || mode_q == M_SLOW)  err_d = 1'b1;
      else if (mul_start)                begin if (!hosc_on_q) err_d = 1'b1; else mul_d = 1'b1; end
      else if (src_q == S_MUL)           err_d = 1'b1;
      else                               mul_d = 1'b0;
    end else if (hosc_wr) begin
      if (hosc_on_req)                            hosc_d = 1'b1;
      else if (mul_on_q || src_q != S_LOSC)       err_d = 1'b1;
      else                                        hosc_d = 1'b0;
    end else if (stby_wr) begin
      if (stby_sel == 2'd3) err_d = 1'b1;
      else                  stby_d = stby_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_NORMAL; src_q <= S_HOSC; gear_q <= 3'd4; stby_q <= 2'd0;
      mul_on_q <= 1'b0; hosc_on_q <= 1'b1; warming_q <= 1'b0; err_q <= 1'b0;
    end else begin
      mode_q <= mode_d; src_q <= src_d; gear_q <= gear_d; stby_q <= stby_d;
      mul_on_q <= mul_d; hosc_on_q <= hosc_d; warming_q <= warm_d; err_q <= err_d;
    end
  end

  AST_MUL_NEEDS_HOSC: assert property (@(posedge clk) disable iff (!rst_n)
    mul_on_q |-> hosc_on_q); // R7
  AST_STOP_NO_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP) |-> !mul_on_q); // R6
  AST_MUL_SRC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == S_MUL) |-> mul_on_q); // R3
  AST_SLOW_MUL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLOW && mul_wr && !sleep_req && !src_wr && !gear_wr)
      |=> ($stable(mul_on_q) && err_q)); // R5
  AST_WAKE_STOP_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STOP && !warming_q && wake_irq) |=> (warming_q && hosc_on_q)); // R10
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import cpm_pkg::*;
#(
  parameter int unsigned CLK_CFG     = 2,
  parameter int unsigned LOSC_DIV    = 100,
  parameter int unsigned LOCK_CYCLES = 20,
  parameter int unsigned WARM_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_wr,
  input  logic [1:0] src_sel,
  input  logic       gear_wr,
  input  logic [2:0] gear_sel,
  input  logic       mul_wr,
  input  logic       mul_start,
  input  logic       hosc_wr,
  input  logic       hosc_on_req,
  input  logic       stby_wr,
  input  logic [1:0] stby_sel,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       mul_lock,
  output logic [2:0] mode,
  output logic       sys_ce,
  output logic       cpu_run,
  output logic       io_run,
  output logic       hosc_run,
  output logic       losc_run,
  output logic       mul_run,
  output logic       req_err
);
  localparam bit          HAS_LOSC = (CLK_CFG != CFG_SINGLE);
  localparam bit          HAS_MUL  = (CLK_CFG == CFG_TRIPLE);
  localparam int unsigned HI_PER   = 2 * MUL_FACTOR * GEAR_MAX;
  localparam int unsigned MAX_PER  = (2 * LOSC_DIV > HI_PER) ? 2 * LOSC_DIV : HI_PER;
  localparam int unsigned PER_W    = $clog2(MAX_PER + 1);

  mode_e      mode_q;
  src_e       src_q;
  logic [2:0] gear_q;
  logic       mul_on, hosc_on, warming, locked, warm_done, tick;

  cpm_fsm #(.HAS_LOSC(HAS_LOSC), .HAS_MUL(HAS_MUL)) u_fsm (
    .clk, .rst_n, .src_wr, .src_sel, .gear_wr, .gear_sel, .mul_wr, .mul_start,
    .hosc_wr, .hosc_on_req, .stby_wr, .stby_sel, .sleep_req, .wake_irq,
    .mul_locked(locked), .warm_done, .mode_q, .src_q, .gear_q,
    .mul_on_q(mul_on), .hosc_on_q(hosc_on), .warming_q(warming), .err_q(req_err)
  );

  generate
    if (HAS_MUL) begin : g_lock
      cpm_qual_cnt #(.LIMIT(LOCK_CYCLES)) u_lock (
        .clk, .rst_n, .run(mul_on & mul_lock), .done(locked)
      );
    end else begin : g_nolock
      assign locked = 1'b0;
    end
  endgenerate

  cpm_qual_cnt #(.LIMIT(WARM_CYCLES)) u_warm (
    .clk, .rst_n, .run(warming), .done(warm_done)
  );

  cpm_ce_div #(.LOSC_DIV(LOSC_DIV), .PER_W(PER_W)) u_div (
    .clk, .rst_n, .src(src_q), .gear(gear_q), .tick
  );

  assign mode     = mode_q;
  assign cpu_run  = (mode_q == M_NORMAL) || (mode_q == M_SLOW);
  assign io_run   = cpu_run || (mode_q == M_IDLE2);
  assign sys_ce   = tick & io_run;
  assign hosc_run = hosc_on & ((mode_q != M_STOP) | warming);
  assign losc_run = HAS_LOSC & (mode_q != M_STOP);
  assign mul_run  = mul_on;
endmodule

// File: tb/clk_pwr_ctrl_bench.sv
module clk_pwr_ctrl_bench;
  localparam int LOSC_DIV = 100, LOCK_CYC = 20, WARM_CYC = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_wr = 0, gear_wr = 0, mul_wr = 0, mul_start = 0, hosc_wr = 0, hosc_on_req = 0;
  logic stby_wr = 0, sleep_req = 0, wake_irq = 0, mul_lock = 0;
  logic [1:0] src_sel = 0, stby_sel = 0;
  logic [2:0] gear_sel = 0;
  logic [2:0] mode;
  logic sys_ce, cpu_run, io_run, hosc_run, losc_run, mul_run, req_err;
  int cyc = 0, n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  clk_pwr_ctrl #(.CLK_CFG(2), .LOSC_DIV(LOSC_DIV), .LOCK_CYCLES(LOCK_CYC),
                 .WARM_CYCLES(WARM_CYC)) u_clk_pwr_ctrl (
    .clk, .rst_n, .src_wr, .src_sel, .gear_wr, .gear_sel, .mul_wr, .mul_start,
    .hosc_wr, .hosc_on_req, .stby_wr, .stby_sel, .sleep_req, .wake_irq, .mul_lock,
    .mode, .sys_ce, .cpu_run, .io_run, .hosc_run, .losc_run, .mul_run, .req_err
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ce(output int t);
    @(negedge clk);
    while (!sys_ce) @(negedge clk);
    t = cyc;
  endtask

  task automatic period(output int p);
    int a, b;
    wait_ce(a);
    wait_ce(b);
    p = b - a;
  endtask

  task automatic wr_src(input logic [1:0] c);
    src_sel = c; src_wr = 1; @(negedge clk); src_wr = 0;
  endtask
  task automatic wr_gear(input logic [2:0] c);
    gear_sel = c; gear_wr = 1; @(negedge clk); gear_wr = 0;
  endtask
  task automatic wr_mul(input logic s);
    mul_start = s; mul_wr = 1; @(negedge clk); mul_wr = 0;
  endtask
  task automatic wr_hosc(input logic s);
    hosc_on_req = s; hosc_wr = 1; @(negedge clk); hosc_wr = 0;
  endtask
  task automatic wr_stby(input logic [1:0] c);
    stby_sel = c; stby_wr = 1; @(negedge clk); stby_wr = 0;
  endtask
  task automatic do_sleep();
    sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask
  task automatic do_wake();
    wake_irq = 1; @(negedge clk); wake_irq = 0;
  endtask

  task automatic t_reset();
    int p;
    chk(mode, 0, "R1 mode"); chk(cpu_run, 1, "R1 cpu_run"); chk(io_run, 1, "R1 io_run");
    chk(hosc_run, 1, "R1 hosc_run"); chk(losc_run, 1, "R1 losc_run");
    chk(mul_run, 0, "R1 mul_run"); chk(req_err, 0, "R1 req_err");
    period(p); chk(p, 128, "R1 reset period");
  endtask

  task automatic t_gear();
    int p;
    wr_gear(3'd0); period(p); chk(p, 8, "R2 gear code0");
    wr_gear(3'd2); period(p); chk(p, 32, "R2 gear code2");
    wr_gear(3'd6); period(p); chk(p, 128, "R2 gear reserved code6");
  endtask

  task automatic t_boundary();
    int t0, t1, t2;
    wait_ce(t0);
    repeat (5) @(negedge clk);
    wr_gear(3'd0);
    wait_ce(t1); chk(t1 - t0, 128, "R8 old period completes");
    wait_ce(t2); chk(t2 - t1, 8, "R8 new period next");
  endtask

  task automatic t_slow();
    int p;
    wr_src(2'd1); chk(req_err, 0, "R4 slow accept"); chk(mode, 1, "R4 mode slow");
    period(p); chk(p, 2 * LOSC_DIV, "R4 slow period");
    wr_mul(1'b1); chk(req_err, 1, "R5 mul in slow err"); chk(mul_run, 0, "R5 mul unchanged");
    wr_src(2'd0); chk(mode, 0, "R4 back to normal");
  endtask

  task automatic t_mul();
    int p;
    wr_mul(1'b1); chk(req_err, 0, "R3 start ok"); chk(mul_run, 1, "R3 mul_run");
    wr_src(2'd2); chk(req_err, 1, "R3 select before lock err");
    mul_lock = 1;
    repeat (LOCK_CYC + 10) @(negedge clk);
    wr_src(2'd2); chk(req_err, 0, "R3 select after lock");
    period(p); chk(p, 2, "R3 mul period");
    wr_hosc(1'b0); chk(req_err, 1, "R7 hosc off with mul err"); chk(hosc_run, 1, "R7 hosc kept");
    wr_mul(1'b0); chk(req_err, 1, "R6 stop while source err"); chk(mul_run, 1, "R6 mul kept");
    wr_stby(2'd2); do_sleep(); chk(req_err, 1, "R6 stop entry err"); chk(mode, 0, "R6 mode kept");
    wr_src(2'd0); chk(req_err, 0, "R6 deselect ok");
    wr_mul(1'b0); chk(req_err, 0, "R6 stop ok"); chk(mul_run, 0, "R6 mul off");
    mul_lock = 0;
    wr_hosc(1'b0); chk(req_err, 1, "R7 hosc off while source err"); chk(hosc_run, 1, "R7 hosc kept2");
  endtask

  task automatic t_idle();
    int n;
    wr_stby(2'd0); do_sleep();
    chk(mode, 2, "R9 idle2 mode"); chk(cpu_run, 0, "R9 idle2 cpu"); chk(io_run, 1, "R9 idle2 io");
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sys_ce) n++; end
    chk(n > 0, 1, "R9 idle2 ce runs");
    do_wake(); chk(mode, 0, "R9 idle2 wake");
    wr_stby(2'd1); do_sleep();
    chk(mode, 3, "R9 idle1 mode"); chk(io_run, 0, "R9 idle1 io");
    chk(hosc_run, 1, "R9 idle1 hosc"); chk(losc_run, 1, "R9 idle1 losc");
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sys_ce) n++; end
    chk(n, 0, "R9 idle1 no ce");
    wr_gear(3'd4); chk(req_err, 1, "R11 write while halted err");
    do_wake(); chk(mode, 0, "R9 idle1 wake");
  endtask

  task automatic t_stop();
    int p;
    wr_src(2'd1); wr_stby(2'd2); do_sleep();
    chk(mode, 4, "R10 stop mode"); chk(cpu_run, 0, "R10 cpu off"); chk(io_run, 0, "R10 io off");
    chk(hosc_run, 0, "R10 hosc off"); chk(losc_run, 0, "R10 losc off"); chk(mul_run, 0, "R10 mul off");
    repeat (10) @(negedge clk);
    do_wake(); chk(hosc_run, 1, "R10 hosc restart"); chk(cpu_run, 0, "R10 cpu held");
    repeat (WARM_CYC / 2) @(negedge clk); chk(cpu_run, 0, "R10 cpu held mid warm");
    repeat (WARM_CYC) @(negedge clk);
    chk(cpu_run, 1, "R10 cpu resumed"); chk(mode, 1, "R10 resume slow");
    period(p); chk(p, 2 * LOSC_DIV, "R10 resume slow period");
  endtask

  task automatic t_reserved();
    wr_stby(2'd3); chk(req_err, 1, "R11 stby code3 err");
    @(negedge clk); chk(req_err, 0, "R11 err one cycle");
    wr_src(2'd3); chk(req_err, 1, "R11 src code3 err"); chk(mode, 1, "R11 mode kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gear();
    t_boundary();
    t_slow();
    t_mul();
    t_idle();
    t_stop();
    t_reserved();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule